// File: doc/BRIEF.md
# Voice Segment Pointer Manager

This block keeps track of the voice segments held by a multi-segment recorder. It stores how many segments exist and which one the current pointer selects. It takes debounced key events as input. Each event carries a key code and the press length in ticks. The block turns these events into pointer moves and into requests to an abstracted memory engine: record, play, erase one segment, chip erase, or stop. When the engine raises its done flag, the block commits the effect of the finished operation to the count and the pointer.

A new recording is placed just behind the current segment, so the memory engine renumbers every later segment. A record, erase or reset that the battery or the memory state forbids is blocked. A blocked operation starts a 3 Hz indicator flash that lasts two seconds. A level-input selects single-segment mode, which allows only one segment. In that mode, an edge-play during playback stops the playback instead of skipping.

Top module: `segmgr_top`

## Requirements
- R1: After reset, segCount is 0 and segPtr is 1. opReq, busy and ledFlash are low. segPtr is 1 whenever segCount is 0, and otherwise lies between 1 and segCount.
- R2: Key codes: record 0, edge-play 1, level-play 2, stop 3, erase 4, forward 5, backward 6, reset 7. Operation kinds: record 0, play 1, erase 2, chip erase 3, stop 4. An accepted record key issues a one-cycle opReq of kind 0 with opSeg = segPtr+1, or opSeg = 1 when segCount is 0. When opDone arrives, segCount rises by one and segPtr takes that new number.
- R3: A record key is rejected, with no opReq and the flash started, when segCount is at the limit (63 in multi-segment mode, 1 in single-segment mode) or when memFull is high.
- R4: An erase key with segCount > 0 issues kind 2 with opSeg = segPtr. On done, segCount falls by one and segPtr moves to segPtr-1, clamped at 1. While the erase is busy, every key except reset has no effect.
- R5: A forward press shorter than LONG_TICKS moves segPtr up by one, clamped at segCount. A longer press moves segPtr to segCount.
- R6: A backward press shorter than LONG_TICKS moves segPtr down by one, clamped at 1. A longer press sets segPtr to 1.
- R7: A reset press shorter than RESET_TICKS sets segPtr to 1, and issues kind 4 if an operation was busy. A longer press issues kind 3. Its done clears segCount to 0 and sets segPtr to 1.
- R8: An edge-play key with segCount > 0 issues kind 1 for segPtr. During playback in multi-segment mode it moves segPtr to the next segment, wrapping from segCount to 1, and issues kind 1 for it. In single-segment mode it issues kind 4 and ends playback.
- R9: Level-play starts playback of segPtr. At each done, while lplayLevel is high, segPtr advances with wrap and a new kind 1 request follows. When lplayLevel is low at done, playback ends.
- R10: A stop key during playback issues kind 4 and drops busy in the same cycle.
- R11: With lowBatt high, a record, erase or reset key issues no request and starts the flash.
- R12: A started flash keeps ledFlash high for HALF_TICKS ticks. It then toggles every HALF_TICKS ticks, and goes low FLASH_TICKS ticks after the start.
- R13: A key event in the same cycle as opDone is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleMode | input | 1 | High selects single-segment mode |
| keyValid | input | 1 | One-cycle strobe of a debounced key event |
| keyCode | input | 3 | Key code of the event |
| keyTicks | input | DUR_W | Press length in ticks |
| lplayLevel | input | 1 | Level-play key still held |
| memFull | input | 1 | Memory engine reports no free space |
| lowBatt | input | 1 | Battery below the safe level |
| tick | input | 1 | Time-base strobe |
| opDone | input | 1 | Memory engine finished the current operation |
| opReq | output | 1 | One-cycle operation request |
| opKind | output | 3 | Kind of the request |
| opSeg | output | SEG_W | Segment number of the request |
| busy | output | 1 | An operation is in progress |
| segCount | output | SEG_W | Number of stored segments |
| segPtr | output | SEG_W | Current segment pointer |
| ledFlash | output | 1 | Indicator flash output |

## Verification
The engine's done flag and a new key event can arrive on the same clock. The main case is an edge-play skip colliding with the end of a playback, and the bench provokes it by raising keyValid and opDone in the same cycle. The reference model applies the completion and drops the key. On the next cycle the bench checks that busy is low, no play request appears and the pointer has not moved. A second case gives a rejected record the same cycle as a flash tick, so a flash restart and a running countdown collide. This case is judged through ledFlash on every clock.

// File: rtl/segmgr_pkg.sv
package segmgr_pkg;

  typedef enum logic [2:0] {
    K_REC   = 3'd0,
    K_EPLAY = 3'd1,
    K_LPLAY = 3'd2,
    K_STOP  = 3'd3,
    K_ERASE = 3'd4,
    K_FWD   = 3'd5,
    K_BWD   = 3'd6,
    K_RESET = 3'd7
  } keyCode_e;

  typedef enum logic [2:0] {
    OP_REC   = 3'd0,
    OP_PLAY  = 3'd1,
    OP_ERASE = 3'd2,
    OP_CHIP  = 3'd3,
    OP_STOP  = 3'd4
  } opKind_e;

  // strobes from the control FSM to the count/pointer datapath
  typedef struct packed {
    logic ptrInc;
    logic ptrDec;
    logic ptrFirst;
    logic ptrLast;
    logic ptrWrap;
    logic cntInc;
    logic cntDec;
    logic clearAll;
    logic flashStart;
  } segStrobe_t;

endpackage

// File: rtl/segLedFlasher.sv
module segLedFlasher #(
  parameter int FLASH_TICKS = 2000,
  parameter int HALF_TICKS  = 167
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic start,
  output logic ledFlash
);
  localparam int RW = $clog2(FLASH_TICKS + 1);
  localparam int PW = $clog2(HALF_TICKS + 1);

  logic          active;
  logic          ledState;
  logic [RW-1:0] remain;
  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      ledState <= 1'b0;
      remain   <= '0;
      phase    <= '0;
    end else if (start) begin
      active   <= 1'b1;
      ledState <= 1'b1;
      remain   <= RW'(FLASH_TICKS);
      phase    <= '0;
    end else if (active && tick) begin
      remain <= remain - RW'(1);
      if (remain == RW'(1)) active <= 1'b0;
      if (phase == PW'(HALF_TICKS - 1)) begin
        phase    <= '0;
        ledState <= ~ledState;
      end else begin
        phase <= phase + PW'(1);
      end
    end
  end

  assign ledFlash = active && ledState;

  // R12: the flash window only counts down on ticks
  a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (active && !start && !tick) |=> $stable(remain));
  // R12: the remaining window never exceeds the programmed length
  a_r12_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    remain <= RW'(FLASH_TICKS));

endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segmgr_pkg::*;
#(
  parameter int MAX_SEG = 63,
  parameter int SEG_W   = $clog2(MAX_SEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             singleMode,
  input  segStrobe_t       stb,
  output logic [SEG_W-1:0] segCount,
  output logic [SEG_W-1:0] segPtr,
  output logic             segEmpty,
  output logic             segFull,
  output logic [SEG_W-1:0] newNum,
  output logic [SEG_W-1:0] wrapNext
);
  localparam logic [SEG_W-1:0] ONE   = SEG_W'(1);
  localparam logic [SEG_W-1:0] LIMIT = SEG_W'(MAX_SEG);

  logic [SEG_W-1:0] cnt, ptr, nCnt, nPtr;
  logic             atLast;

  assign segEmpty = (cnt == '0);
  assign atLast   = (ptr >= cnt);
  assign segFull  = singleMode ? (cnt >= ONE) : (cnt >= LIMIT);
  assign newNum   = segEmpty ? ONE : ptr + ONE;
  assign wrapNext = atLast ? ONE : ptr + ONE;

  always_comb begin
    nCnt = cnt;
    nPtr = ptr;
    if (stb.clearAll) begin
      nCnt = '0;
      nPtr = ONE;
    end else if (stb.cntInc) begin
      nCnt = cnt + ONE;
      nPtr = newNum;
    end else if (stb.cntDec) begin
      nCnt = cnt - ONE;
      nPtr = (ptr > ONE) ? ptr - ONE : ONE;
    end else if (stb.ptrFirst) begin
      nPtr = ONE;
    end else if (stb.ptrLast) begin
      nPtr = segEmpty ? ONE : cnt;
    end else if (stb.ptrInc) begin
      nPtr = (ptr < cnt) ? ptr + ONE : ptr;
    end else if (stb.ptrDec) begin
      nPtr = (ptr > ONE) ? ptr - ONE : ONE;
    end else if (stb.ptrWrap) begin
      nPtr = wrapNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      ptr <= ONE;
    end else begin
      cnt <= nCnt;
      ptr <= nPtr;
    end
  end

  assign segCount = cnt;
  assign segPtr   = ptr;

  // R1: pointer stays inside the stored range, 1 when empty
  a_r1_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) ? (ptr == ONE) : (ptr >= ONE && ptr <= cnt));
  // R3: count never passes the segment limit
  a_r3_count_limit: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIMIT);
  // R2: a count increase is always a single step
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (cnt > $past(cnt)) |-> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/segCtrl.sv
module segCtrl
  import segmgr_pkg::*;
#(
  parameter int SEG_W       = 6,
  parameter int DUR_W       = 16,
  parameter int LONG_TICKS  = 1000,
  parameter int RESET_TICKS = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             singleMode,
  input  logic             keyValid,
  input  logic [2:0]       keyCode,
  input  logic [DUR_W-1:0] keyTicks,
  input  logic             lplayLevel,
  input  logic             memFull,
  input  logic             lowBatt,
  input  logic             opDone,
  input  logic             segEmpty,
  input  logic             segFull,
  input  logic [SEG_W-1:0] newNum,
  input  logic [SEG_W-1:0] wrapNext,
  input  logic [SEG_W-1:0] segPtr,
  output segStrobe_t       stb,
  output logic             opReq,
  output logic [2:0]       opKind,
  output logic [SEG_W-1:0] opSeg,
  output logic             busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_REC, ST_PLAY, ST_ERASE, ST_CHIP} state_e;

  state_e           state, nState;
  logic             loopPlay, nLoop;
  logic             reqV;
  opKind_e          reqK;
  logic [SEG_W-1:0] reqS;
  logic             ev, isLong, isRLong, doReset;
  keyCode_e         kc;

  assign kc      = keyCode_e'(keyCode);
  assign ev      = keyValid && !opDone;
  assign isLong  = keyTicks >= DUR_W'(LONG_TICKS);
  assign isRLong = keyTicks >= DUR_W'(RESET_TICKS);

  always_comb begin
    stb     = '0;
    nState  = state;
    nLoop   = loopPlay;
    reqV    = 1'b0;
    reqK    = OP_STOP;
    reqS    = segPtr;
    doReset = 1'b0;
    case (state)
      ST_IDLE: if (ev) begin
        case (kc)
          K_REC: if (lowBatt || segFull || memFull) stb.flashStart = 1'b1;
                 else begin reqV = 1'b1; reqK = OP_REC; reqS = newNum; nState = ST_REC; end
          K_EPLAY, K_LPLAY: if (!segEmpty) begin
            reqV = 1'b1; reqK = OP_PLAY; nLoop = (kc == K_LPLAY); nState = ST_PLAY;
          end
          K_ERASE: if (lowBatt) stb.flashStart = 1'b1;
                   else if (!segEmpty) begin reqV = 1'b1; reqK = OP_ERASE; nState = ST_ERASE; end
          K_FWD:   if (isLong) stb.ptrLast = 1'b1; else stb.ptrInc = 1'b1;
          K_BWD:   if (isLong) stb.ptrFirst = 1'b1; else stb.ptrDec = 1'b1;
          K_RESET: doReset = 1'b1;
          default: ;
        endcase
      end
      ST_REC: begin
        if (opDone) begin stb.cntInc = 1'b1; nState = ST_IDLE; end
        else if (ev && kc == K_RESET) doReset = 1'b1;
      end
      ST_PLAY: begin
        if (opDone) begin
          if (loopPlay && lplayLevel) begin
            stb.ptrWrap = 1'b1; reqV = 1'b1; reqK = OP_PLAY; reqS = wrapNext;
          end else nState = ST_IDLE;
        end else if (ev) begin
          case (kc)
            K_STOP: begin reqV = 1'b1; nState = ST_IDLE; end
            K_EPLAY: if (singleMode) begin reqV = 1'b1; nState = ST_IDLE; end
                     else begin stb.ptrWrap = 1'b1; reqV = 1'b1; reqK = OP_PLAY; reqS = wrapNext; end
            K_RESET: doReset = 1'b1;
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (opDone) begin stb.cntDec = 1'b1; nState = ST_IDLE; end
        else if (ev && kc == K_RESET) doReset = 1'b1;
      end
      ST_CHIP: if (opDone) begin stb.clearAll = 1'b1; nState = ST_IDLE; end
      default: nState = ST_IDLE;
    endcase

    if (doReset) begin
      if (lowBatt) stb.flashStart = 1'b1;
      else if (isRLong) begin
        reqV = 1'b1; reqK = OP_CHIP; nState = ST_CHIP;
      end else begin
        stb.ptrFirst = 1'b1;
        nState = ST_IDLE;
        if (state != ST_IDLE) begin reqV = 1'b1; reqK = OP_STOP; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      loopPlay <= 1'b0;
      opReq    <= 1'b0;
      opKind   <= OP_STOP;
      opSeg    <= '0;
    end else begin
      state    <= nState;
      loopPlay <= nLoop;
      opReq    <= reqV;
      opKind   <= reqK;
      opSeg    <= reqS;
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: nothing but reset reaches the engine while an erase runs
  a_r4_erase_locks: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && !opDone && !(keyValid && kc == K_RESET)) |=> (!opReq && $stable(segPtr)));
  // R10: a stop request always leaves the block idle
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opKind == OP_STOP) |-> !busy);
  // R2: a record request always leaves the block busy
  a_r2_rec_busy: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opKind == OP_REC) |-> busy);

endmodule

// File: rtl/segmgr_top.sv
module segmgr_top
  import segmgr_pkg::*;
#(
  parameter int MAX_SEG     = 63,
  parameter int DUR_W       = 16,
  parameter int LONG_TICKS  = 1000,
  parameter int RESET_TICKS = 2000,
  parameter int FLASH_TICKS = 2000,
  parameter int HALF_TICKS  = 167,
  localparam int SEG_W      = $clog2(MAX_SEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             singleMode,
  input  logic             keyValid,
  input  logic [2:0]       keyCode,
  input  logic [DUR_W-1:0] keyTicks,
  input  logic             lplayLevel,
  input  logic             memFull,
  input  logic             lowBatt,
  input  logic             tick,
  input  logic             opDone,
  output logic             opReq,
  output logic [2:0]       opKind,
  output logic [SEG_W-1:0] opSeg,
  output logic             busy,
  output logic [SEG_W-1:0] segCount,
  output logic [SEG_W-1:0] segPtr,
  output logic             ledFlash
);
  segStrobe_t       stb;
  logic             segEmpty, segFull;
  logic [SEG_W-1:0] newNum, wrapNext;

  segCtrl #(.SEG_W(SEG_W), .DUR_W(DUR_W), .LONG_TICKS(LONG_TICKS), .RESET_TICKS(RESET_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .singleMode(singleMode), .keyValid(keyValid), .keyCode(keyCode),
    .keyTicks(keyTicks), .lplayLevel(lplayLevel), .memFull(memFull), .lowBatt(lowBatt),
    .opDone(opDone), .segEmpty(segEmpty), .segFull(segFull), .newNum(newNum),
    .wrapNext(wrapNext), .segPtr(segPtr), .stb(stb), .opReq(opReq), .opKind(opKind),
    .opSeg(opSeg), .busy(busy));

  segDatapath #(.MAX_SEG(MAX_SEG), .SEG_W(SEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .singleMode(singleMode), .stb(stb), .segCount(segCount),
    .segPtr(segPtr), .segEmpty(segEmpty), .segFull(segFull), .newNum(newNum),
    .wrapNext(wrapNext));

  segLedFlasher #(.FLASH_TICKS(FLASH_TICKS), .HALF_TICKS(HALF_TICKS)) u_flash (
    .clk(clk), .rstN(rstN), .tick(tick), .start(stb.flashStart), .ledFlash(ledFlash));

endmodule

// File: tb/segmgr_top_tb.sv
`timescale 1ns/1ps
module segmgr_top_tb;
  localparam int LONG = 10, RLONG = 20, FL = 20, HALF = 3, LIM = 63;

  logic clk = 0, rstN = 0, singleMode = 0, keyValid = 0, lplayLevel = 0;
  logic memFull = 0, lowBatt = 0, tick = 0, opDone = 0;
  logic [2:0] keyCode = 0;
  logic [15:0] keyTicks = 0;
  logic opReq, busy, ledFlash;
  logic [2:0] opKind;
  logic [5:0] opSeg, segCount, segPtr;

  int checks = 0, errors = 0, tickCnt = 0;
  bit finished = 0;

  segmgr_top #(.MAX_SEG(LIM), .DUR_W(16), .LONG_TICKS(LONG), .RESET_TICKS(RLONG),
               .FLASH_TICKS(FL), .HALF_TICKS(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .singleMode(singleMode), .keyValid(keyValid), .keyCode(keyCode),
    .keyTicks(keyTicks), .lplayLevel(lplayLevel), .memFull(memFull), .lowBatt(lowBatt),
    .tick(tick), .opDone(opDone), .opReq(opReq), .opKind(opKind), .opSeg(opSeg),
    .busy(busy), .segCount(segCount), .segPtr(segPtr), .ledFlash(ledFlash));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % 4;
    tick = (tickCnt == 0);
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCount = 0, mPtr = 1, mState = 0, mLoop = 0, mRecNum = 0;
  int eReq = 0, eKind = 0, eSeg = 0;
  int fAct = 0, fLed = 0, fRem = 0, fPh = 0;

  function automatic int nextWrap();
    return (mPtr >= mCount) ? 1 : mPtr + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mPtr = 1; mState = 0; mLoop = 0; eReq = 0;
      fAct = 0; fLed = 0; fRem = 0; fPh = 0;
    end else begin
      bit ev, doRst, flashGo, lng;
      int lim, k, oldState;
      ev = keyValid && !opDone;   // R13: completion wins, key dropped
      k = keyCode; lng = (keyTicks >= LONG);
      lim = singleMode ? 1 : LIM;
      doRst = 0; flashGo = 0; eReq = 0; oldState = mState;
      if (mState == 0) begin
        if (ev) begin
          if (k == 0) begin
            if (lowBatt || memFull || mCount >= lim) flashGo = 1;
            else begin eReq = 1; eKind = 0; eSeg = (mCount == 0) ? 1 : mPtr + 1; mRecNum = eSeg; mState = 1; end
          end else if (k == 1 || k == 2) begin
            if (mCount > 0) begin eReq = 1; eKind = 1; eSeg = mPtr; mLoop = (k == 2); mState = 2; end
          end else if (k == 4) begin
            if (lowBatt) flashGo = 1;
            else if (mCount > 0) begin eReq = 1; eKind = 2; eSeg = mPtr; mState = 3; end
          end else if (k == 5) begin
            if (lng) mPtr = (mCount == 0) ? 1 : mCount;
            else if (mPtr < mCount) mPtr++;
          end else if (k == 6) begin
            if (lng || mPtr <= 1) mPtr = 1; else mPtr--;
          end else if (k == 7) doRst = 1;
        end
      end else if (mState == 1) begin
        if (opDone) begin mCount++; mPtr = mRecNum; mState = 0; end
        else if (ev && k == 7) doRst = 1;
      end else if (mState == 2) begin
        if (opDone) begin
          if (mLoop && lplayLevel) begin mPtr = nextWrap(); eReq = 1; eKind = 1; eSeg = mPtr; end
          else mState = 0;
        end else if (ev) begin
          if (k == 3) begin eReq = 1; eKind = 4; mState = 0; end
          else if (k == 1) begin
            if (singleMode) begin eReq = 1; eKind = 4; mState = 0; end
            else begin mPtr = nextWrap(); eReq = 1; eKind = 1; eSeg = mPtr; end
          end else if (k == 7) doRst = 1;
        end
      end else if (mState == 3) begin
        if (opDone) begin mCount--; mPtr = (mPtr > 1) ? mPtr - 1 : 1; mState = 0; end
        else if (ev && k == 7) doRst = 1;
      end else begin
        if (opDone) begin mCount = 0; mPtr = 1; mState = 0; end
      end
      if (doRst) begin
        if (lowBatt) flashGo = 1;
        else if (keyTicks >= RLONG) begin eReq = 1; eKind = 3; mState = 4; end
        else begin
          mPtr = 1; mState = 0;
          if (oldState != 0) begin eReq = 1; eKind = 4; end
        end
      end
      if (flashGo) begin fAct = 1; fLed = 1; fRem = FL; fPh = 0; end
      else if (fAct && tick) begin
        fRem--; if (fRem == 0) fAct = 0;
        if (fPh == HALF - 1) begin fPh = 0; fLed = !fLed; end else fPh++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(segCount, mCount, "R2 count");
      check(segPtr, mPtr, "R5 pointer");
      check(opReq, eReq, "R13 request");
      if (eReq && opReq) begin
        check(opKind, eKind, "R8 kind");
        if (eKind <= 2) check(opSeg, eSeg, "R2 segment");
      end
      check(busy, mState != 0, "R4 busy");
      check(ledFlash, fAct && fLed, "R12 flash");
    end
  end

  // ---------------- stimulus ----------------
  task automatic press(input int code, input int ticks);
    @(negedge clk); keyValid = 1; keyCode = 3'(code); keyTicks = 16'(ticks);
    @(negedge clk); keyValid = 0;
  endtask

  task automatic done();
    @(negedge clk); opDone = 1;
    @(negedge clk); opDone = 0;
  endtask

  task automatic pressWithDone(input int code);
    @(negedge clk); keyValid = 1; keyCode = 3'(code); keyTicks = 1; opDone = 1;
    @(negedge clk); keyValid = 0; opDone = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual 0 expected 1 (run not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(segCount, 0, "R1"); check(segPtr, 1, "R1"); check(busy, 0, "R1");
    check(opReq, 0, "R1"); check(ledFlash, 0, "R1");

    // R2 record into empty memory and insertion
    press(0, 1); check(opReq, 1, "R2"); check(opKind, 0, "R2"); check(opSeg, 1, "R2");
    done(); check(segCount, 1, "R2"); check(segPtr, 1, "R2");
    press(0, 1); check(opSeg, 2, "R2"); done();
    press(6, 1); check(segPtr, 1, "R6");
    press(0, 1); check(opSeg, 2, "R2"); done();
    check(segCount, 3, "R2"); check(segPtr, 2, "R2");

    // R5 / R6 moves and clamps
    press(5, 1); check(segPtr, 3, "R5");
    press(5, 1); check(segPtr, 3, "R5");
    press(6, LONG); check(segPtr, 1, "R6");
    press(6, 1); check(segPtr, 1, "R6");
    press(5, LONG + 5); check(segPtr, 3, "R5");

    // R4 erase with locked keys
    press(4, 1); check(opKind, 2, "R4"); check(opSeg, 3, "R4"); check(busy, 1, "R4");
    press(6, 1); check(segPtr, 3, "R4"); check(opReq, 0, "R4");
    press(0, 1); check(opReq, 0, "R4");
    done(); check(segCount, 2, "R4"); check(segPtr, 2, "R4");

    // R8 edge-play skip with wrap, R10 stop
    press(1, 1); check(opKind, 1, "R8"); check(opSeg, 2, "R8");
    press(1, 1); check(segPtr, 1, "R8"); check(opSeg, 1, "R8");
    press(3, 1); check(opKind, 4, "R10"); check(busy, 0, "R10");

    // R9 level-play loop
    lplayLevel = 1;
    press(2, 1); check(opSeg, 1, "R9");
    done(); check(segPtr, 2, "R9"); check(opSeg, 2, "R9");
    done(); check(segPtr, 1, "R9"); check(opReq, 1, "R9");
    lplayLevel = 0;
    done(); check(busy, 0, "R9"); check(opReq, 0, "R9");

    // R13 key in the same cycle as completion
    press(1, 1);
    pressWithDone(1); check(busy, 0, "R13"); check(opReq, 0, "R13"); check(segPtr, 1, "R13");

    // R11 / R12 low battery and flash
    lowBatt = 1;
    press(0, 1); check(opReq, 0, "R11"); check(ledFlash, 1, "R11");
    press(4, 1); check(opReq, 0, "R11"); check(segCount, 2, "R11");
    press(7, RLONG); check(opReq, 0, "R11"); check(busy, 0, "R11");
    lowBatt = 0;
    repeat (100) @(negedge clk); check(ledFlash, 0, "R12");

    // R3 memory full and segment limit
    memFull = 1; press(0, 1); check(opReq, 0, "R3"); check(ledFlash, 1, "R3"); memFull = 0;
    while (segCount < LIM) begin press(0, 1); done(); end
    press(0, 1); check(opReq, 0, "R3"); check(segCount, LIM, "R3");

    // R7 short reset then chip erase
    press(7, 3); check(segPtr, 1, "R7");
    press(7, RLONG); check(opKind, 3, "R7"); check(busy, 1, "R7");
    done(); check(segCount, 0, "R7"); check(segPtr, 1, "R7");

    // single-segment mode: limit 1 (R3), edge-play stops (R8)
    singleMode = 1;
    press(0, 1); done(); check(segCount, 1, "R3");
    press(0, 1); check(opReq, 0, "R3");
    press(1, 1); check(busy, 1, "R8");
    press(1, 1); check(opKind, 4, "R8"); check(busy, 0, "R8");
    singleMode = 0;
    repeat (10) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule